// File: doc/BRIEF.md
# Shared Interrupt Aggregator with Four Gated Outputs

This block gathers a parameterized number of peripheral interrupt sources into sticky pending bits held in 32-bit words, and it drives four CPU interrupt lines. Each line has its own bank of enable words, one word per status word, so any source can be routed to any combination of lines. Each line is also gated by an all-enable bit. That bit sits at bit 0 of the first enable word in the line's bank, which is why source index 0 is reserved.

Software reaches the block through a simple synchronous register port. The port gives access to the raw status words, a write-one-to-clear word for each status word, and the enable banks. Pending state is captured whether or not any enable is set. A handler that drops a line's all-enable for one cycle and then raises it again gets a fresh rising edge on that line if enabled work is still pending.

Top module: `shared_irq_agg`

## Requirements
- R1: Each source input passes through a two-stage synchronizer. A rising edge then sets that source's pending bit on the third clock edge after the input changes. A level held high sets the bit only once.
- R2: A pending bit stays set until software clears it, including while no output enables it. It asserts a line as soon as that line's enable for the bit and its all-enable are both set.
- R3: A write to clear word w clears exactly the pending bits of word w that are written as one and leaves the bits written as zero unchanged. If a new rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A status word reads the raw pending bits whatever the enables are, and reading it changes nothing. A clear word reads as zero. Read data is registered and appears one clock after the address.
- R5: Output o has an independent enable word for every status word. Enable words read back the value last written to them.
- R6: Output o is high only when bit 0 of its enable word 0 is one and at least one source is both pending and enabled in bank o.
- R7: Each output is registered and follows the gated result one clock later. Dropping the all-enable for one cycle gives one low cycle followed by a rising edge when enabled pending sources remain.
- R8: Source 0 is reserved, and its pending bit always reads as zero.
- R9: With W status words the register map is as follows. Address a < W is status word a. Addresses W to 2W-1 are clear words. Address 2W + o*W + w is enable word w of output o. Any other address reads zero. With the defaults (64 sources, W = 2) this gives status words at 0 and 1, clear words at 2 and 3, and enable words at 4 to 11.
- R10: Reset clears all synchronizer, pending and enable state, the read data and every output.
- R11: With every enable word written to zero, all outputs stay low while pending capture continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcIn | input | NUM_SRC | Asynchronous interrupt source levels |
| regAddr | input | ADDR_W | Register word address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWrData | input | WORD_W | Write data |
| regRdData | output | WORD_W | Registered read data of the previous cycle's address |
| irqOut | output | NUM_OUT | Registered interrupt lines to the CPU |

## Verification
A source change reaches the pending bit on the third rising edge. It reaches the lines on the fourth edge, and it appears on the read data on the fourth edge when the status address is held. Enable, gate and clear writes take effect at their own edge, and the lines and read data show the result one edge later. The bench drives inputs on falling edges. It steps a behavioural model on each rising edge and compares the lines and the read data with the model on every falling edge. Directed checks are timed to these latencies, and one of them deliberately lines up a clear with a rising edge on the same bit.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  // strobes from register decode to the datapath
  typedef struct packed {
    logic clrStb;   // write to a clear word
    logic enStb;    // write to an enable word
    logic rdStatus; // address selects a status word
    logic rdEnable; // address selects an enable word
  } ctrlStrobeT;
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUT   = 4,
  parameter int ADDR_W    = 4,
  parameter int WIDX_W    = 1,
  parameter int BIDX_W    = 2
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strobe,
  output logic [WIDX_W-1:0] wordIdx,
  output logic [BIDX_W-1:0] bankIdx
);
  localparam int CLR_BASE = NUM_WORDS;
  localparam int EN_BASE  = 2 * NUM_WORDS;
  localparam int REG_END  = EN_BASE + NUM_OUT * NUM_WORDS;

  int addrInt;
  int enOff;

  always_comb begin
    addrInt = int'(regAddr);
    enOff   = addrInt - EN_BASE;
    strobe  = '0;
    wordIdx = '0;
    bankIdx = '0;
    if (addrInt < CLR_BASE) begin
      strobe.rdStatus = 1'b1;
      wordIdx = WIDX_W'(addrInt);
    end else if (addrInt < EN_BASE) begin
      strobe.clrStb = regWr;
      wordIdx = WIDX_W'(addrInt - CLR_BASE);
    end else if (addrInt < REG_END) begin
      strobe.enStb    = regWr;
      strobe.rdEnable = 1'b1;
      wordIdx = WIDX_W'(enOff % NUM_WORDS);
      bankIdx = BIDX_W'(enOff / NUM_WORDS);
    end
  end
endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int NUM_OUT     = 4,
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WIDX_W      = 1,
  parameter int BIDX_W      = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          srcIn,
  input  ctrlStrobeT                  strobe,
  input  logic [WIDX_W-1:0]           wordIdx,
  input  logic [BIDX_W-1:0]           bankIdx,
  input  logic [WORD_W-1:0]           wrData,
  output logic [WORD_W-1:0]           rdData,
  output logic [NUM_OUT-1:0]          irqOut,
  output logic [NUM_WORDS*WORD_W-1:0] pendVec,
  output logic [NUM_OUT-1:0]          gateVec
);
  localparam int PEND_W = NUM_WORDS * WORD_W;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] srcRise;
  logic [PEND_W-1:0]  riseWide;
  logic [PEND_W-1:0]  clrMask;
  logic [PEND_W-1:0]  pendReg;
  logic [PEND_W-1:0]  pendNext;
  logic [PEND_W-1:0]  enBank [NUM_OUT];
  logic [NUM_OUT-1:0] hitVec;
  logic [NUM_OUT-1:0] irqNext;

  // synchronizer chain plus previous-level flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      srcPrev <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      srcPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign srcRise = syncQ[SYNC_STAGES-1] & ~srcPrev;

  always_comb begin
    riseWide = '0;
    riseWide[NUM_SRC-1:0] = srcRise;
    riseWide[0] = 1'b0; // index 0 belongs to the all-enable gate
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign clrMask[w*WORD_W +: WORD_W] =
      (strobe.clrStb && wordIdx == WIDX_W'(w)) ? wrData : '0;
  end

  // a new edge wins over a simultaneous clear
  assign pendNext = (pendReg & ~clrMask) | riseWide;

  always_ff @(posedge clk) begin
    if (rst) pendReg <= '0;
    else     pendReg <= pendNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < NUM_OUT; o++) enBank[o] <= '0;
    end else if (strobe.enStb) begin
      enBank[bankIdx][wordIdx*WORD_W +: WORD_W] <= wrData;
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign gateVec[o] = enBank[o][0];
    assign hitVec[o]  = |(pendReg & enBank[o]);
    assign irqNext[o] = gateVec[o] & hitVec[o];
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= '0;
    else     irqOut <= irqNext;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobe.rdStatus) rdData <= pendReg[wordIdx*WORD_W +: WORD_W];
    else if (strobe.rdEnable) rdData <= enBank[bankIdx][wordIdx*WORD_W +: WORD_W];
    else                      rdData <= '0;
  end

  assign pendVec = pendReg;
endmodule

// File: rtl/shared_irq_agg.sv
module shared_irq_agg
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int NUM_OUT     = 4,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_WORDS  = (NUM_SRC + WORD_W - 1) / WORD_W,
  localparam int NUM_REGS   = (2 + NUM_OUT) * NUM_WORDS,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  output logic [NUM_OUT-1:0] irqOut
);
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int BIDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  ctrlStrobeT                  strobe;
  logic [WIDX_W-1:0]           wordIdx;
  logic [BIDX_W-1:0]           bankIdx;
  logic [NUM_WORDS*WORD_W-1:0] pendVec;
  logic [NUM_OUT-1:0]          gateVec;

  irqagg_ctrl #(
    .NUM_WORDS(NUM_WORDS), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W),
    .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)
  ) u_ctrl (
    .regWr(regWr), .regAddr(regAddr), .strobe(strobe),
    .wordIdx(wordIdx), .bankIdx(bankIdx)
  );

  irqagg_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .WORD_W(WORD_W),
    .NUM_WORDS(NUM_WORDS), .SYNC_STAGES(SYNC_STAGES),
    .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .srcIn(srcIn), .strobe(strobe),
    .wordIdx(wordIdx), .bankIdx(bankIdx), .wrData(regWrData),
    .rdData(regRdData), .irqOut(irqOut), .pendVec(pendVec),
    .gateVec(gateVec)
  );
endmodule

// File: rtl/shared_irq_agg_chk.sv
module shared_irq_agg_chk #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_OUT   = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           regAddr,
  input logic                        regWr,
  input logic [WORD_W-1:0]           regRdData,
  input logic [NUM_OUT-1:0]          irqOut,
  input logic [NUM_WORDS*WORD_W-1:0] pendVec,
  input logic [NUM_OUT-1:0]          gateVec
);
  logic clrHit;
  assign clrHit = (int'(regAddr) >= NUM_WORDS) && (int'(regAddr) < 2 * NUM_WORDS);

  // R2: without a clear write, no pending bit is lost
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(regWr && clrHit) |-> ((pendVec & $past(pendVec)) == $past(pendVec)));

  // R8: reserved source never shows pending
  a_r8_src0_zero: assert property (@(posedge clk) disable iff (rst)
    pendVec[0] == 1'b0);

  // R4: clear words read back as zero
  a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    $past(clrHit) |-> regRdData == '0);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    // R6: a line is only raised when its gate was open
    a_r6_gate_required: assert property (@(posedge clk) disable iff (rst)
      irqOut[o] |-> $past(gateVec[o]));
    // R7: closing the gate drops the line on the next edge
    a_r7_gate_drop: assert property (@(posedge clk) disable iff (rst)
      $fell(gateVec[o]) |=> !irqOut[o]);
  end
endmodule

bind shared_irq_agg shared_irq_agg_chk #(
  .NUM_WORDS(NUM_WORDS), .NUM_OUT(NUM_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_shared_irq_agg.sv
module test_shared_irq_agg;
  localparam int NS = 64;
  localparam int NO = 4;
  localparam int WW = 32;
  localparam int NW = 2;
  localparam int PW = NW * WW;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] srcIn = '0;
  logic [AW-1:0] regAddr = '0;
  logic          regWr = 1'b0;
  logic [WW-1:0] regWrData = '0;
  logic [WW-1:0] regRdData;
  logic [NO-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R10";

  shared_irq_agg i_shared_irq_agg (
    .clk(clk), .rst(rst), .srcIn(srcIn), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  // behavioural reference model, stepped on every rising edge
  bit [NS-1:0] mS1, mS2, mS3;
  bit [PW-1:0] mPend;
  bit [PW-1:0] mEn [NO];
  bit [NO-1:0] mIrq;
  bit [WW-1:0] mRd;

  always @(posedge clk) begin
    if (rst) begin
      mS1 = '0; mS2 = '0; mS3 = '0; mPend = '0; mIrq = '0; mRd = '0;
      for (int o = 0; o < NO; o++) mEn[o] = '0;
    end else begin
      int a;
      bit [PW-1:0] pn;
      bit [NS-1:0] rise;
      a = int'(regAddr);
      if (a < NW) mRd = mPend[a*WW +: WW];
      else if (a < 2*NW) mRd = '0;
      else if (a < 2*NW + NO*NW) mRd = mEn[(a-2*NW)/NW][((a-2*NW)%NW)*WW +: WW];
      else mRd = '0;
      for (int o = 0; o < NO; o++) mIrq[o] = mEn[o][0] && ((mPend & mEn[o]) != '0);
      pn = mPend;
      if (regWr && a >= NW && a < 2*NW)
        for (int b = 0; b < WW; b++) if (regWrData[b]) pn[(a-NW)*WW + b] = 1'b0;
      rise = mS2 & ~mS3;
      for (int b = 1; b < NS; b++) if (rise[b]) pn[b] = 1'b1;
      mPend = pn;
      if (regWr && a >= 2*NW && a < 2*NW + NO*NW)
        mEn[(a-2*NW)/NW][((a-2*NW)%NW)*WW +: WW] = regWrData;
      mS3 = mS2; mS2 = mS1; mS1 = srcIn;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL %s model irqOut actual=%b expected=%b", curReq, irqOut, mIrq);
      end
      checks++;
      if (regRdData !== mRd) begin
        errors++;
        $display("FAIL %s model regRdData actual=%h expected=%h", curReq, regRdData, mRd);
      end
    end
  end

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [WW-1:0] d);
    regAddr = AW'(a); regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input string req, input int a, input logic [WW-1:0] exp);
    regAddr = AW'(a);
    @(negedge clk);
    check(req, regRdData, exp);
  endtask

  task automatic pulse(input int s);
    srcIn[s] = 1'b1;
    @(negedge clk);
    srcIn[s] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 irq after reset", WW'(irqOut), 0);
    rst = 1'b0;
    regRead("R10 status after reset", 0, 0);

    curReq = "R8";
    pulse(0);
    regRead("R8 source 0 reads zero", 0, 0);

    curReq = "R1";
    pulse(5);
    regRead("R1 edge sets pending", 0, 32'h20);
    check("R2 pending but not enabled", WW'(irqOut), 0);

    curReq = "R6";
    regWrite(4, 32'h20);
    repeat (2) @(negedge clk);
    check("R6 no gate keeps line low", WW'(irqOut), 0);
    regWrite(4, 32'h21);
    @(negedge clk);
    check("R2 delivered once enabled", WW'(irqOut), 32'h1);

    curReq = "R5";
    regWrite(8, 32'h1);
    regWrite(9, 32'h100);
    pulse(40);
    check("R5 routed to line 2 only", WW'(irqOut), 32'h5);
    regRead("R4 status word 1", 1, 32'h100);

    curReq = "R7";
    regWrite(4, 32'h20);
    regWrite(4, 32'h21);
    check("R7 gate pulse low cycle", WW'(irqOut[0]), 0);
    @(negedge clk);
    check("R7 gate pulse new edge", WW'(irqOut[0]), 1);

    curReq = "R3";
    pulse(7);
    regWrite(2, 32'h0);
    regRead("R3 zero mask clears nothing", 0, 32'hA0);
    regWrite(2, 32'h20);
    regRead("R3 one clears bit 5 only", 0, 32'h80);
    check("R3 line 0 drops after clear", WW'(irqOut[0]), 0);
    srcIn[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrite(2, 32'h200);
    srcIn[9] = 1'b0;
    regRead("R3 set wins over clear", 0, 32'h280);

    curReq = "R4";
    regRead("R4 repeat read no side effect", 0, 32'h280);
    regRead("R4 clear word reads zero", 2, 0);
    regRead("R5 enable readback", 4, 32'h21);
    regRead("R5 enable readback line 2", 9, 32'h100);

    curReq = "R11";
    for (int a = 4; a < 12; a++) regWrite(a, 0);
    pulse(12);
    check("R11 all lines masked", WW'(irqOut), 0);
    regRead("R11 capture continues", 0, 32'h1280);

    curReq = "R9";
    for (int a = 12; a < 16; a++) regRead("R9 unmapped reads zero", a, 0);
    regRead("R9 status word 1 address", 1, 32'h100);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog %s actual=hung expected=finished", curReq);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule